// File: doc/BRIEF.md
# Serial Gain-Control Register with Readback

This block holds the 9-bit control word of a programmable gain/attenuator stage. In serial mode a word is clocked in one bit at a time on a data line under an external shift clock. A capture strobe then copies the shift register into a holding latch, and the latch drives the gain-select outputs. A readback strobe copies the latch back into the shift register, so the stored word can be clocked out on a serial output, one new bit per falling edge of the shift clock. A new word can be shifted in while the old one is shifted out.

In parallel mode the serial path is bypassed. The gain-select outputs follow a set of direct input pins, and the serial strobes and shift clock have no effect. In both modes the block also drives a signed coarse-gain value in half-dB units, derived from the selected word.

The external serial pins are asynchronous to the system clock. Each one passes through a synchronizer, and its edges are detected in the system clock domain. Because the logic is static, the shift clock and strobes may run at any slow rate, either in bursts or continuously.

Top module: `serial_gain_ctl`

## Requirements
- R1: After reset, the shift register, the latch and the serial output are zero. In serial mode this gives atten_o=0, coarse_o=0, fine_o=0, gain_hdb_o=0 and sod_o=0.
- R2: Each rising shift-clock edge shifts sdi_i into the word. After 9 edges the first bit sits in word bit 0. The word layout is bits [3:0] fine, bits [7:4] coarse and bit 8 attenuate, so the shift order is fine bit 0 first and the attenuate bit last. A rising edge of lat_in_i copies the whole word to the latch, and the latch drives atten_o, coarse_o and fine_o.
- R3: In serial mode, shifting without a rising lat_in_i edge leaves atten_o, coarse_o and fine_o unchanged.
- R4: A rising edge of lat_out_i loads the latched word into the shift register, and sod_o presents word bit 0 at once. After the k-th following falling shift-clock edge (k = 1 to 8), sod_o presents word bit k.
- R5: If a readback load and a rising shift-clock edge are detected in the same cycle, the load wins and the shift is lost. sod_o then presents bit 0 both after the load and after the next falling edge, and bit k after the k-th full shift-clock cycle that follows.
- R6: With ser_mode_i low, atten_o, coarse_o and fine_o follow par_atten_i, par_coarse_i and par_fine_i directly.
- R7: With ser_mode_i low, the shift clock and both strobes have no effect. On return to serial mode, the outputs show the word latched before parallel mode began.
- R8: gain_hdb_o equals +3 × coarse_o when atten_o is 0 and −3 × coarse_o when atten_o is 1, in two's complement over 7 bits.
- R9: A word shifted in with arbitrarily long pauses between shift-clock edges latches the same as one shifted in without pauses.
- R10: During a readback, the bits presented on sdi_i on the 9 rising edges form a new word, and a following lat_in_i edge latches that new word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ser_mode_i | input | 1 | 1 = serial path, 0 = direct pins |
| sck_i | input | 1 | Serial shift clock (asynchronous) |
| sdi_i | input | 1 | Serial data in |
| lat_in_i | input | 1 | Capture strobe, shift register to latch |
| lat_out_i | input | 1 | Readback strobe, latch to shift register |
| sod_o | output | 1 | Serial data out |
| par_atten_i | input | 1 | Direct attenuate select |
| par_coarse_i | input | 4 | Direct coarse code |
| par_fine_i | input | 4 | Direct fine code |
| atten_o | output | 1 | Selected attenuate bit |
| coarse_o | output | 4 | Selected coarse code |
| fine_o | output | 4 | Selected fine code |
| gain_hdb_o | output | 7 | Signed coarse gain in 0.5 dB units |

## Verification
Several asymmetric words are loaded: 0x1A5, 0x0F0, 0x15A and a word with only the attenuate bit set. A reversed shift order or a misplaced field boundary therefore shows up in the decoded fields and in the sign and size of the gain. One load uses long pauses between edges, to show that the result does not depend on timing. Readback is tried twice. One run uses a clean strobe while the shift clock is low and shifts a fresh word in at the same time. The other run makes the strobe collide with a shift-clock rise, which separates load-over-shift priority from the reverse. Parallel mode is tried with two pin patterns, and also with serial traffic running, which must leave the latched word untouched.

// File: rtl/gain_ctl_pkg.sv
package gain_ctl_pkg;
  localparam int FINE_W   = 4;
  localparam int COARSE_W = 4;
  localparam int WORD_W   = FINE_W + COARSE_W + 1;
  localparam int GAIN_W   = 7;
  localparam int STEP_HDB = 3;

  typedef struct packed {
    logic                atten;
    logic [COARSE_W-1:0] coarse;
    logic [FINE_W-1:0]   fine;
  } gain_word_t;
endpackage

// File: rtl/gc_sync.sv
module gc_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= d_i;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/gc_shift_reg.sv
module gc_shift_reg
  import gain_ctl_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       shift_i,
  input  logic       fall_i,
  input  logic       load_i,
  input  logic       sdi_i,
  input  gain_word_t load_word_i,
  output gain_word_t word_o,
  output logic       sod_o
);
  logic [WORD_W-1:0] sreg_q;
  logic              sod_q;

  // load beats shift; rise and fall never coincide
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sreg_q <= '0;
      sod_q  <= 1'b0;
    end else if (load_i) begin
      sreg_q <= load_word_i;
      sod_q  <= load_word_i.fine[0];
    end else if (shift_i) begin
      sreg_q <= {sdi_i, sreg_q[WORD_W-1:1]};
    end else if (fall_i) begin
      sod_q  <= sreg_q[0];
    end
  end

  assign word_o = gain_word_t'(sreg_q);
  assign sod_o  = sod_q;
endmodule

// File: rtl/gc_latch.sv
module gc_latch
  import gain_ctl_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cap_i,
  input  gain_word_t word_i,
  output gain_word_t word_o
);
  gain_word_t hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    hold_q <= '0;
    else if (cap_i) hold_q <= word_i;
  end

  assign word_o = hold_q;
endmodule

// File: rtl/gc_gain_decode.sv
module gc_gain_decode
  import gain_ctl_pkg::*;
(
  input  gain_word_t        word_i,
  output logic [GAIN_W-1:0] gain_o
);
  logic [GAIN_W-1:0] mag;

  always_comb begin
    mag    = GAIN_W'(word_i.coarse) * GAIN_W'(STEP_HDB);
    gain_o = word_i.atten ? (~mag + 1'b1) : mag;
  end
endmodule

// File: rtl/serial_gain_ctl.sv
module serial_gain_ctl
  import gain_ctl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     ser_mode_i,
  input  logic                     sck_i,
  input  logic                     sdi_i,
  input  logic                     lat_in_i,
  input  logic                     lat_out_i,
  output logic                     sod_o,
  input  logic                     par_atten_i,
  input  logic [COARSE_W-1:0]      par_coarse_i,
  input  logic [FINE_W-1:0]        par_fine_i,
  output logic                     atten_o,
  output logic [COARSE_W-1:0]      coarse_o,
  output logic [FINE_W-1:0]        fine_o,
  output logic signed [GAIN_W-1:0] gain_hdb_o
);
  localparam int N_PIN = 4;
  localparam int I_SCK = 0, I_SDI = 1, I_LIN = 2, I_LOUT = 3;

  logic [N_PIN-1:0] pin_raw, pin_s;
  logic             sck_prev_q, lin_prev_q, lout_prev_q;
  logic             sck_rise, sck_fall, lin_rise, lout_rise;
  logic             shift_en, fall_en, load_en, cap_en;
  gain_word_t       sreg_word, latch_word, par_word, sel_word;
  logic [GAIN_W-1:0] gain_raw;

  assign pin_raw = {lat_out_i, lat_in_i, sdi_i, sck_i};

  gc_sync #(.W(N_PIN), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_raw),
    .q_o   (pin_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_prev_q  <= 1'b0;
      lin_prev_q  <= 1'b0;
      lout_prev_q <= 1'b0;
    end else begin
      sck_prev_q  <= pin_s[I_SCK];
      lin_prev_q  <= pin_s[I_LIN];
      lout_prev_q <= pin_s[I_LOUT];
    end
  end

  assign sck_rise  = pin_s[I_SCK]  & ~sck_prev_q;
  assign sck_fall  = ~pin_s[I_SCK] &  sck_prev_q;
  assign lin_rise  = pin_s[I_LIN]  & ~lin_prev_q;
  assign lout_rise = pin_s[I_LOUT] & ~lout_prev_q;

  // serial events are dropped while the direct pins own the outputs
  assign shift_en = ser_mode_i & sck_rise;
  assign fall_en  = ser_mode_i & sck_fall;
  assign load_en  = ser_mode_i & lout_rise;
  assign cap_en   = ser_mode_i & lin_rise;

  gc_shift_reg u_sreg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .shift_i    (shift_en),
    .fall_i     (fall_en),
    .load_i     (load_en),
    .sdi_i      (pin_s[I_SDI]),
    .load_word_i(latch_word),
    .word_o     (sreg_word),
    .sod_o      (sod_o)
  );

  gc_latch u_latch (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .cap_i (cap_en),
    .word_i(sreg_word),
    .word_o(latch_word)
  );

  assign par_word = '{atten: par_atten_i, coarse: par_coarse_i, fine: par_fine_i};
  assign sel_word = ser_mode_i ? latch_word : par_word;

  gc_gain_decode u_dec (
    .word_i(sel_word),
    .gain_o(gain_raw)
  );

  assign atten_o    = sel_word.atten;
  assign coarse_o   = sel_word.coarse;
  assign fine_o     = sel_word.fine;
  assign gain_hdb_o = $signed(gain_raw);
endmodule

// File: rtl/serial_gain_ctl_chk.sv
module serial_gain_ctl_chk
  import gain_ctl_pkg::*;
(
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     ser_mode_i,
  input logic                     par_atten_i,
  input logic [COARSE_W-1:0]      par_coarse_i,
  input logic [FINE_W-1:0]        par_fine_i,
  input logic                     atten_o,
  input logic [COARSE_W-1:0]      coarse_o,
  input logic [FINE_W-1:0]        fine_o,
  input logic signed [GAIN_W-1:0] gain_hdb_o,
  input logic                     sod_o,
  input logic                     cap_en,
  input logic                     load_en,
  input gain_word_t               sreg_word,
  input gain_word_t               latch_word
);
  a_r2_capture_copies: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_en |=> latch_word == $past(sreg_word));

  a_r3_latch_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_en |=> $stable(latch_word));

  a_r4_readback_first_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_en |=> sod_o == $past(latch_word.fine[0]));

  a_r5_load_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_en |=> sreg_word == $past(latch_word));

  a_r6_direct_pins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ser_mode_i |-> (atten_o == par_atten_i && coarse_o == par_coarse_i && fine_o == par_fine_i));

  a_r7_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ser_mode_i |=> ($stable(sreg_word) && $stable(latch_word)));

  a_r8_gain_value: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(gain_hdb_o) == (atten_o ? -3 : 3) * int'(coarse_o));
endmodule

bind serial_gain_ctl serial_gain_ctl_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ser_mode_i  (ser_mode_i),
  .par_atten_i (par_atten_i),
  .par_coarse_i(par_coarse_i),
  .par_fine_i  (par_fine_i),
  .atten_o     (atten_o),
  .coarse_o    (coarse_o),
  .fine_o      (fine_o),
  .gain_hdb_o  (gain_hdb_o),
  .sod_o       (sod_o),
  .cap_en      (cap_en),
  .load_en     (load_en),
  .sreg_word   (sreg_word),
  .latch_word  (latch_word)
);

// File: tb/serial_gain_ctl_test.sv
module serial_gain_ctl_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_mode = 1'b1, sck = 1'b0, sdi = 1'b0, lat_in = 1'b0, lat_out = 1'b0;
  logic par_atten = 1'b0;
  logic [3:0] par_coarse = '0, par_fine = '0;
  logic sod, atten;
  logic [3:0] coarse, fine;
  logic signed [6:0] gain;

  int total = 0, bad = 0;
  bit done = 0;
  int exp_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;

  serial_gain_ctl uut (
    .clk_i(clk), .rst_ni(rst_n), .ser_mode_i(ser_mode), .sck_i(sck), .sdi_i(sdi),
    .lat_in_i(lat_in), .lat_out_i(lat_out), .sod_o(sod),
    .par_atten_i(par_atten), .par_coarse_i(par_coarse), .par_fine_i(par_fine),
    .atten_o(atten), .coarse_o(coarse), .fine_o(fine), .gain_hdb_o(gain)
  );

  task automatic gap(input int n);
    repeat (n) @(negedge clk);
  endtask

  // driver side: expected items
  task automatic push(input string tag, input int v);
    exp_q.push_back(v);
    tag_q.push_back(tag);
  endtask

  // monitor side: pop and compare
  task automatic pop_cmp(input int act);
    int e;
    string t;
    e = exp_q.pop_front();
    t = tag_q.pop_front();
    total++;
    if (act !== e) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", t, act, e);
    end
  endtask

  function automatic int gain_of(input logic [8:0] w);
    return (w[8] ? -3 : 3) * int'(w[7:4]);
  endfunction

  task automatic expect_word(input string tag, input logic [8:0] w);
    push(tag, int'(w));
    pop_cmp(int'({atten, coarse, fine}));
    push(tag, gain_of(w));
    pop_cmp(int'(gain));
  endtask

  task automatic sck_cycle(input logic b, input int pause);
    sdi = b; gap(5 + pause);
    sck = 1'b1; gap(5 + pause);
    sck = 1'b0; gap(5);
  endtask

  task automatic strobe_in();
    lat_in = 1'b1; gap(5);
    lat_in = 1'b0; gap(5);
  endtask

  task automatic shift_word(input logic [8:0] w, input int pause);
    for (int k = 0; k < 9; k++) sck_cycle(w[k], pause);
  endtask

  initial begin
    logic [8:0] w_a, w_b, w_c, w_d, w_n;
    w_a = 9'h1A5; w_b = 9'h0F0; w_c = 9'h15A; w_d = 9'h100; w_n = 9'h0C3;
    gap(3);
    // R1 reset state
    push("R1 word", 0); pop_cmp(int'({atten, coarse, fine}));
    push("R1 gain", 0); pop_cmp(int'(gain));
    push("R1 sod", 0);  pop_cmp(int'(sod));
    rst_n = 1'b1; gap(3);

    // R2 / R8 several words
    shift_word(w_a, 0); strobe_in(); expect_word("R2 R8 word 1A5", w_a);
    shift_word(w_b, 0); strobe_in(); expect_word("R2 R8 word 0F0", w_b);
    shift_word(w_d, 0); strobe_in(); expect_word("R2 R8 atten only", w_d);

    // R3 shifting without capture keeps outputs
    shift_word(w_c, 0); expect_word("R3 no capture", w_d);
    strobe_in(); expect_word("R2 word 15A", w_c);

    // R9 long pauses
    shift_word(w_a, 200); strobe_in(); expect_word("R9 slow load", w_a);

    // R4 / R10 readback while shifting a new word in
    lat_out = 1'b1; gap(5); lat_out = 1'b0; gap(5);
    push("R4 bit0", int'(w_a[0])); pop_cmp(int'(sod));
    for (int k = 0; k < 9; k++) begin
      sck_cycle(w_n[k], 0);
      if (k < 8) begin
        push($sformatf("R4 bit%0d", k + 1), int'(w_a[k + 1])); pop_cmp(int'(sod));
      end
    end
    expect_word("R10 outputs before capture", w_a);
    strobe_in(); expect_word("R10 new word", w_n);

    // R5 collision: readback strobe with shift-clock rise in the same cycle
    sdi = 1'b1; gap(5);
    lat_out = 1'b1; sck = 1'b1; gap(5);
    push("R5 bit0 after load", int'(w_n[0])); pop_cmp(int'(sod));
    sck = 1'b0; lat_out = 1'b0; gap(5);
    push("R5 bit0 after fall", int'(w_n[0])); pop_cmp(int'(sod));
    for (int k = 1; k < 9; k++) begin
      sck_cycle(1'b0, 0);
      push($sformatf("R5 bit%0d", k), int'(w_n[k])); pop_cmp(int'(sod));
    end

    // R6 / R8 parallel pins
    ser_mode = 1'b0;
    par_atten = 1'b1; par_coarse = 4'hF; par_fine = 4'h3; gap(2);
    expect_word("R6 R8 pins -45", 9'h1F3);
    par_atten = 1'b0; par_coarse = 4'h6; par_fine = 4'hA; gap(2);
    expect_word("R6 R8 pins +18", 9'h06A);

    // R7 serial traffic ignored in parallel mode
    shift_word(w_b, 0); strobe_in();
    lat_out = 1'b1; gap(5); lat_out = 1'b0; gap(5);
    expect_word("R7 pins still drive", 9'h06A);
    ser_mode = 1'b1; gap(2);
    expect_word("R7 latch kept", w_n);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule